// File: doc/BRIEF.md
# UART FIFO Trigger Interrupt Controller

This block turns FIFO occupancy into interrupt requests for one serial channel. Each cycle it compares the transmit and receive FIFO counts against trigger thresholds. The thresholds come from 3-bit control fields, scaled by a factor that depends on the channel the block is built for. From these comparisons it sets bits in a source register. It also collects one-cycle event requests for receive timeout, line error and modem change.

A mask register filters the source bits into a pending register. One interrupt line goes high whenever any pending bit is set. Software clears bits by writing ones to the pending or source register through write strobes. A second output tells a receive DMA engine that it has nothing to fetch.

The FIFOs and the timeout timer live outside the block. The block only sees their counts and the timeout's one-cycle request.

Top module: `uart_trig_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the source, pending and mask registers are cleared, and `irq` and `dma_busy` are low after that edge.
- R2: Source bit positions are: receive = bit 0, error = bit 1, transmit = bit 2, modem = bit 3. A cycle with `err_evt` high sets bit 1 at the next edge, and a cycle with `modem_evt` high sets bit 3.
- R3: With `fifo_en` high, a cycle where `tx_count` <= `tx_trig` * scale sets source bit 2 at the next edge.
- R4: With `fifo_en` high, a cycle where `rx_count` >= (`rx_trig` + 1) * scale sets source bit 0 at the next edge.
- R5: With `fifo_en` high and `rx_tmo_en` low, any nonzero `rx_count` sets source bit 0 at the next edge, whatever the threshold.
- R6: With `fifo_en` low, `rx_ready` high sets source bit 0, and the FIFO counts set no source bit.
- R7: A cycle with `tmo_req` high sets source bit 0 at the next edge.
- R8: The scale is fixed by the parameter `CHANNEL`:
  - 32 for channel 0;
  - 8 for channels 1 and 4;
  - 2 for channels 2 and 3;
  - 0 for any other channel, which gives a threshold of 0.
- R9: Both `pend` and `irq` are registered. `pend` equals the next source value AND NOT the next mask value, and `irq` is high exactly when `pend` is nonzero. A mask written with `mask_wr` applies from the same edge that stores it.
- R10: Clearing rules:
  - A `pend_wr` write clears the source bits written as one, and so the matching pending bits.
  - A `src_wr` write clears the source bits written as one; pending follows because it is recomputed every cycle.
  - A set condition in the same cycle wins over a clear.
- R11: `dma_busy` is registered. It is high after an edge where `rx_mode` was 2 (binary 10) and `rx_count` was 0, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_tmo_en | input | 1 | Receive timeout enable |
| rx_mode | input | 2 | Receive mode field; value 2 selects DMA |
| tx_trig | input | FLD_W | Transmit trigger field |
| rx_trig | input | FLD_W | Receive trigger field (offset by one) |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_ready | input | 1 | Receive data-ready flag, used when FIFOs are off |
| tmo_req | input | 1 | Receive timeout request pulse |
| err_evt | input | 1 | Error event pulse |
| modem_evt | input | 1 | Modem event pulse |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 4 | Mask write data |
| pend_wr | input | 1 | Pending register write strobe (write-one-to-clear) |
| pend_wdata | input | 4 | Pending write data |
| src_wr | input | 1 | Source register write strobe (write-one-to-clear) |
| src_wdata | input | 4 | Source write data |
| src_pend | output | 4 | Source register |
| pend | output | 4 | Masked pending register |
| irq | output | 1 | Interrupt request |
| dma_busy | output | 1 | Receive DMA busy |

## Verification
The checker module tests these properties on every clock:
- the reset state;
- that `irq` agrees with `pend`, and `pend` never holds a bit absent from the source register;
- the transmit threshold, the FIFO-off receive path, timeout and event setting;
- a full mask silencing the line;
- the `dma_busy` rule.

Other behaviours only the bench scenarios can show:
- the exact threshold edges for three channel scalings, including the zero-scale channel;
- the one-offset receive threshold;
- the immediate receive request when the timeout is off;
- set-over-clear priority;
- the difference between source and pending clears.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;
  localparam int SRC_W     = 4;
  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;
  localparam int MAX_SCALE = 32;

  // Threshold multiplier per channel index.
  function automatic int unsigned trig_scale(input int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_trig_level.sv
module uart_trig_level #(
  parameter int unsigned CHANNEL = 0,
  parameter int FLD_W  = 3,
  parameter int LVL_W  = 9,
  parameter bit ADD_ONE = 1'b0
) (
  input  logic [FLD_W-1:0] fld,
  output logic [LVL_W-1:0] lvl
);
  localparam int unsigned SCALE = uart_trig_pkg::trig_scale(CHANNEL);

  generate
    if (SCALE == 0) begin : g_zero
      assign lvl = '0;
    end else begin : g_scaled
      logic [LVL_W-1:0] base;
      assign base = LVL_W'(fld) + LVL_W'(ADD_ONE);
      assign lvl  = LVL_W'(base * LVL_W'(SCALE));
    end
  endgenerate
endmodule

// File: rtl/uart_trig_srcgen.sv
module uart_trig_srcgen
  import uart_trig_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int FLD_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             fifo_en,
  input  logic             rx_tmo_en,
  input  logic [FLD_W-1:0] tx_trig,
  input  logic [FLD_W-1:0] rx_trig,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_ready,
  input  logic             tmo_req,
  input  logic             err_evt,
  input  logic             modem_evt,
  output logic [SRC_W-1:0] set_vec
);
  localparam int LVL_W = $clog2(((1 << FLD_W) * MAX_SCALE) + 1);
  localparam int CMP_W = (LVL_W > CNT_W) ? LVL_W : CNT_W;

  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic [CMP_W-1:0] tx_cnt_x, rx_cnt_x, tx_lvl_x, rx_lvl_x;
  logic tx_hit, rx_hit, rx_any;

  uart_trig_level #(.CHANNEL(CHANNEL), .FLD_W(FLD_W), .LVL_W(LVL_W), .ADD_ONE(1'b0))
    u_tx_lvl (.fld(tx_trig), .lvl(tx_lvl));
  uart_trig_level #(.CHANNEL(CHANNEL), .FLD_W(FLD_W), .LVL_W(LVL_W), .ADD_ONE(1'b1))
    u_rx_lvl (.fld(rx_trig), .lvl(rx_lvl));

  assign tx_cnt_x = CMP_W'(tx_count);
  assign rx_cnt_x = CMP_W'(rx_count);
  assign tx_lvl_x = CMP_W'(tx_lvl);
  assign rx_lvl_x = CMP_W'(rx_lvl);

  assign tx_hit = tx_cnt_x <= tx_lvl_x;
  assign rx_hit = rx_cnt_x >= rx_lvl_x;
  assign rx_any = (rx_count != '0) && !rx_tmo_en;

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_TX]    = fifo_en && tx_hit;
    set_vec[SRC_RX]    = (fifo_en ? (rx_hit || rx_any) : rx_ready) || tmo_req;
    set_vec[SRC_ERR]   = err_evt;
    set_vec[SRC_MODEM] = modem_evt;
  end
endmodule

// File: rtl/uart_trig_pendreg.sv
module uart_trig_pendreg
  import uart_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] set_vec,
  input  logic             mask_wr,
  input  logic [SRC_W-1:0] mask_wdata,
  input  logic             pend_wr,
  input  logic [SRC_W-1:0] pend_wdata,
  input  logic             src_wr,
  input  logic [SRC_W-1:0] src_wdata,
  output logic [SRC_W-1:0] src_q,
  output logic [SRC_W-1:0] pend_q,
  output logic             irq_q
);
  logic [SRC_W-1:0] mask_q, mask_d, clr_vec, src_d, pend_d;

  assign clr_vec = (pend_wr ? pend_wdata : '0) | (src_wr ? src_wdata : '0);
  assign mask_d  = mask_wr ? mask_wdata : mask_q;

  genvar b;
  generate
    for (b = 0; b < SRC_W; b++) begin : g_bit
      // A live set condition overrides a clear in the same cycle.
      assign src_d[b]  = set_vec[b] | (src_q[b] & ~clr_vec[b]);
      assign pend_d[b] = src_d[b] & ~mask_d[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
      irq_q  <= |pend_d;
    end
  end
endmodule

// File: rtl/uart_trig_irq_ctrl.sv
module uart_trig_irq_ctrl
  import uart_trig_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int FLD_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             rx_tmo_en,
  input  logic [1:0]       rx_mode,
  input  logic [FLD_W-1:0] tx_trig,
  input  logic [FLD_W-1:0] rx_trig,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_ready,
  input  logic             tmo_req,
  input  logic             err_evt,
  input  logic             modem_evt,
  input  logic             mask_wr,
  input  logic [SRC_W-1:0] mask_wdata,
  input  logic             pend_wr,
  input  logic [SRC_W-1:0] pend_wdata,
  input  logic             src_wr,
  input  logic [SRC_W-1:0] src_wdata,
  output logic [SRC_W-1:0] src_pend,
  output logic [SRC_W-1:0] pend,
  output logic             irq,
  output logic             dma_busy
);
  localparam logic [1:0] RX_MODE_DMA = 2'd2;

  logic [SRC_W-1:0] set_vec;

  uart_trig_srcgen #(.CHANNEL(CHANNEL), .FLD_W(FLD_W), .CNT_W(CNT_W)) u_srcgen (
    .fifo_en(fifo_en), .rx_tmo_en(rx_tmo_en),
    .tx_trig(tx_trig), .rx_trig(rx_trig),
    .tx_count(tx_count), .rx_count(rx_count),
    .rx_ready(rx_ready), .tmo_req(tmo_req),
    .err_evt(err_evt), .modem_evt(modem_evt),
    .set_vec(set_vec)
  );

  uart_trig_pendreg u_pendreg (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .pend_wr(pend_wr), .pend_wdata(pend_wdata),
    .src_wr(src_wr), .src_wdata(src_wdata),
    .src_q(src_pend), .pend_q(pend), .irq_q(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) dma_busy <= 1'b0;
    else     dma_busy <= (rx_mode == RX_MODE_DMA) && (rx_count == '0);
  end
endmodule

// File: rtl/uart_trig_irq_chk.sv
module uart_trig_irq_chk
  import uart_trig_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int FLD_W = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic [1:0]       rx_mode,
  input logic [FLD_W-1:0] tx_trig,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_ready,
  input logic             tmo_req,
  input logic             err_evt,
  input logic             modem_evt,
  input logic             mask_wr,
  input logic [SRC_W-1:0] mask_wdata,
  input logic [SRC_W-1:0] src_pend,
  input logic [SRC_W-1:0] pend,
  input logic             irq,
  input logic             dma_busy
);
  localparam int unsigned SC = trig_scale(CHANNEL);
  int unsigned tx_lim;
  assign tx_lim = int'(tx_trig) * SC;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (src_pend == '0 && pend == '0 && !irq && !dma_busy));
  // R9
  a_r9_irq_tracks_pend: assert property (@(posedge clk) disable iff (rst)
    irq == (pend != '0));
  a_r9_pend_within_src: assert property (@(posedge clk) disable iff (rst)
    (pend & ~src_pend) == '0);
  a_r9_full_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && mask_wdata == '1) |=> (pend == '0 && !irq));
  // R3
  a_r3_tx_threshold: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && int'(tx_count) <= tx_lim) |=> src_pend[SRC_TX]);
  // R6
  a_r6_ready_no_fifo: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && rx_ready) |=> src_pend[SRC_RX]);
  // R7
  a_r7_timeout_sets_rx: assert property (@(posedge clk) disable iff (rst)
    tmo_req |=> src_pend[SRC_RX]);
  // R2
  a_r2_events_set: assert property (@(posedge clk) disable iff (rst)
    (err_evt && modem_evt) |=> (src_pend[SRC_ERR] && src_pend[SRC_MODEM]));
  // R11
  a_r11_dma_busy: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dma_busy == $past(rx_mode == 2'd2 && rx_count == '0)));
endmodule

bind uart_trig_irq_ctrl uart_trig_irq_chk #(.CHANNEL(CHANNEL), .FLD_W(FLD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_mode(rx_mode),
  .tx_trig(tx_trig), .tx_count(tx_count), .rx_count(rx_count),
  .rx_ready(rx_ready), .tmo_req(tmo_req), .err_evt(err_evt), .modem_evt(modem_evt),
  .mask_wr(mask_wr), .mask_wdata(mask_wdata),
  .src_pend(src_pend), .pend(pend), .irq(irq), .dma_busy(dma_busy)
);

// File: tb/uart_trig_irq_ctrl_tb.sv
module uart_trig_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  // Scales chosen per R8 for channels 1, 3 and 6.
  localparam int SCALES [NI] = '{8, 2, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 0, rx_tmo_en = 0, rx_ready = 0, tmo_req = 0, err_evt = 0, modem_evt = 0;
  logic [1:0] rx_mode = 0;
  logic [2:0] tx_trig = 0, rx_trig = 0;
  logic [7:0] tx_count = 0, rx_count = 0;
  logic mask_wr = 0, pend_wr = 0, src_wr = 0;
  logic [3:0] mask_wdata = 0, pend_wdata = 0, src_wdata = 0;

  logic [3:0] o_src [NI];
  logic [3:0] o_pend [NI];
  logic       o_irq [NI];
  logic       o_dma [NI];

  int checks = 0, failures = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_trig_irq_ctrl #(.CHANNEL(1)) dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_tmo_en(rx_tmo_en), .rx_mode(rx_mode),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_count(tx_count), .rx_count(rx_count),
    .rx_ready(rx_ready), .tmo_req(tmo_req), .err_evt(err_evt), .modem_evt(modem_evt),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .pend_wr(pend_wr), .pend_wdata(pend_wdata),
    .src_wr(src_wr), .src_wdata(src_wdata),
    .src_pend(o_src[0]), .pend(o_pend[0]), .irq(o_irq[0]), .dma_busy(o_dma[0]));
  uart_trig_irq_ctrl #(.CHANNEL(3)) dut_b (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_tmo_en(rx_tmo_en), .rx_mode(rx_mode),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_count(tx_count), .rx_count(rx_count),
    .rx_ready(rx_ready), .tmo_req(tmo_req), .err_evt(err_evt), .modem_evt(modem_evt),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .pend_wr(pend_wr), .pend_wdata(pend_wdata),
    .src_wr(src_wr), .src_wdata(src_wdata),
    .src_pend(o_src[1]), .pend(o_pend[1]), .irq(o_irq[1]), .dma_busy(o_dma[1]));
  uart_trig_irq_ctrl #(.CHANNEL(6)) dut_z (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_tmo_en(rx_tmo_en), .rx_mode(rx_mode),
    .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_count(tx_count), .rx_count(rx_count),
    .rx_ready(rx_ready), .tmo_req(tmo_req), .err_evt(err_evt), .modem_evt(modem_evt),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .pend_wr(pend_wr), .pend_wdata(pend_wdata),
    .src_wr(src_wr), .src_wdata(src_wdata),
    .src_pend(o_src[2]), .pend(o_pend[2]), .irq(o_irq[2]), .dma_busy(o_dma[2]));

  // Behavioural reference model
  logic [3:0] m_src [NI] = '{4'h0, 4'h0, 4'h0};
  logic [3:0] m_pend [NI] = '{4'h0, 4'h0, 4'h0};
  logic [3:0] m_mask = 4'h0;
  logic       m_dma = 1'b0;

  function automatic logic [3:0] model_set(int sc);
    logic [3:0] s = 4'h0;
    int txl = int'(tx_trig) * sc;
    int rxl = (int'(rx_trig) + 1) * sc;
    if (fifo_en) begin
      if (int'(tx_count) <= txl) s[2] = 1'b1;
      if ((rx_count != 0 && !rx_tmo_en) || int'(rx_count) >= rxl) s[0] = 1'b1;
    end else if (rx_ready) s[0] = 1'b1;
    if (tmo_req)   s[0] = 1'b1;
    if (err_evt)   s[1] = 1'b1;
    if (modem_evt) s[3] = 1'b1;
    return s;
  endfunction

  always @(posedge clk) begin
    logic [3:0] mn, cl, sn;
    if (rst) begin
      for (int k = 0; k < NI; k++) begin m_src[k] <= 4'h0; m_pend[k] <= 4'h0; end
      m_mask <= 4'h0; m_dma <= 1'b0;
    end else begin
      mn = mask_wr ? mask_wdata : m_mask;
      cl = (pend_wr ? pend_wdata : 4'h0) | (src_wr ? src_wdata : 4'h0);
      for (int k = 0; k < NI; k++) begin
        sn = (m_src[k] & ~cl) | model_set(SCALES[k]);
        m_src[k]  <= sn;
        m_pend[k] <= sn & ~mn;
      end
      m_mask <= mn;
      m_dma  <= (rx_mode == 2'd2) && (rx_count == 0);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int k = 0; k < NI; k++) begin
        chk({cur_req, " src"}, 32'(o_src[k]), 32'(m_src[k]));
        chk({cur_req, " R9 pend"}, 32'(o_pend[k]), 32'(m_pend[k]));
        chk({cur_req, " R9 irq"}, 32'(o_irq[k]), 32'(m_pend[k] != 0));
        chk({cur_req, " R11 dma"}, 32'(o_dma[k]), 32'(m_dma));
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    cmp_on = 1;
    cyc();
    // R1: reset state
    chk("R1 src", 32'(o_src[0]), 0); chk("R1 irq", 32'(o_irq[0]), 0);
    chk("R1 dma", 32'(o_dma[0]), 0);

    // R6: FIFOs off, counts ignored, ready sets rx
    cur_req = "R6";
    tx_count = 0; rx_count = 5; cyc(2);
    chk("R6 counts ignored", 32'(o_src[0]), 0);
    rx_ready = 1; cyc();
    chk("R6 ready sets rx", 32'(o_src[0]), 4'h1);
    rx_ready = 0; rx_count = 0; pend_wr = 1; pend_wdata = 4'hF; cyc();
    pend_wr = 0; cyc();
    chk("R10 pend clear", 32'(o_src[0]), 0);

    // R3 / R8: transmit threshold, field 2 -> 16 (ch1), 4 (ch3), 0 (ch6)
    cur_req = "R3";
    fifo_en = 1; rx_tmo_en = 1; rx_trig = 7; rx_count = 0;
    tx_trig = 2; tx_count = 20; cyc(2);
    chk("R3 above level", 32'(o_src[0][2]), 0);
    tx_count = 16; cyc();
    chk("R3 at level ch1", 32'(o_src[0][2]), 1);
    chk("R8 ch3 scale 2", 32'(o_src[1][2]), 0);
    tx_count = 4; cyc();
    chk("R8 ch3 at level", 32'(o_src[1][2]), 1);
    chk("R8 ch6 level zero", 32'(o_src[2][2]), 0);
    // R10: set wins over clear while condition holds
    cur_req = "R10";
    src_wr = 1; src_wdata = 4'h4; cyc(); src_wr = 0;
    chk("R10 set wins", 32'(o_src[0][2]), 1);
    tx_count = 30; cyc();
    src_wr = 1; src_wdata = 4'h4; cyc(); src_wr = 0;
    chk("R10 src clear", 32'(o_src[0][2]), 0);
    tx_count = 0; cyc();
    chk("R8 ch6 zero count", 32'(o_src[2][2]), 1);
    tx_count = 200; src_wr = 1; src_wdata = 4'hF; cyc(); src_wr = 0; cyc();

    // R4: rx field 1 -> (1+1)*8=16 ch1, 4 ch3, 0 ch6
    cur_req = "R4";
    rx_trig = 1; rx_count = 3; cyc(2);
    chk("R4 below", 32'(o_src[0][0]), 0);
    chk("R8 ch6 rx level 0", 32'(o_src[2][0]), 1);
    rx_count = 4; cyc();
    chk("R4 ch3 at level", 32'(o_src[1][0]), 1);
    chk("R4 ch1 below", 32'(o_src[0][0]), 0);
    rx_count = 15; cyc();
    chk("R4 offset-by-one", 32'(o_src[0][0]), 0);
    rx_count = 16; cyc();
    chk("R4 ch1 at level", 32'(o_src[0][0]), 1);
    rx_count = 0; src_wr = 1; src_wdata = 4'hF; cyc(); src_wr = 0; cyc();

    // R5: timeout disabled, any data raises rx
    cur_req = "R5";
    rx_tmo_en = 0; rx_count = 1; cyc();
    chk("R5 immediate rx", 32'(o_src[0][0]), 1);
    rx_count = 0; rx_tmo_en = 1; src_wr = 1; src_wdata = 4'h1; cyc(); src_wr = 0; cyc();
    chk("R5 cleared", 32'(o_src[0][0]), 0);

    // R7 and R2: pulses
    cur_req = "R7";
    tmo_req = 1; cyc(); tmo_req = 0;
    chk("R7 timeout sets rx", 32'(o_src[0]), 4'h1);
    cur_req = "R2";
    err_evt = 1; cyc(); err_evt = 0;
    chk("R2 err bit1", 32'(o_src[0]), 4'h3);
    modem_evt = 1; cyc(); modem_evt = 0;
    chk("R2 modem bit3", 32'(o_src[0]), 4'hB);

    // R9: masking
    cur_req = "R9";
    mask_wr = 1; mask_wdata = 4'h9; cyc(); mask_wr = 0;
    chk("R9 masked pend", 32'(o_pend[0]), 4'h2);
    chk("R9 irq", 32'(o_irq[0]), 1);
    mask_wr = 1; mask_wdata = 4'hF; cyc(); mask_wr = 0;
    chk("R9 all masked", 32'(o_irq[0]), 0);
    mask_wr = 1; mask_wdata = 4'h0; cyc(); mask_wr = 0;
    chk("R9 unmasked", 32'(o_pend[0]), 4'hB);
    // R10: pend write vs src write
    cur_req = "R10";
    pend_wr = 1; pend_wdata = 4'h8; cyc(); pend_wr = 0;
    chk("R10 pend clears src", 32'(o_src[0]), 4'h3);
    src_wr = 1; src_wdata = 4'h2; cyc(); src_wr = 0;
    chk("R10 src clears pend", 32'(o_pend[0]), 4'h1);

    // R11: DMA busy
    cur_req = "R11";
    rx_mode = 2; rx_count = 0; cyc();
    chk("R11 busy", 32'(o_dma[0]), 1);
    rx_count = 2; cyc();
    chk("R11 data present", 32'(o_dma[0]), 0);
    rx_mode = 1; rx_count = 0; cyc();
    chk("R11 other mode", 32'(o_dma[0]), 0);
    rx_mode = 2; cyc(2);

    // R1: reset mid-run
    cur_req = "R1";
    mask_wr = 1; mask_wdata = 4'h5; cyc(); mask_wr = 0;
    rst = 1; cyc(); rst = 0;
    chk("R1 mid-run src", 32'(o_src[0]), 0);
    chk("R1 mid-run dma", 32'(o_dma[0]), 0);
    fifo_en = 0; rx_mode = 0; cyc();
    rx_ready = 1; cyc(); rx_ready = 0;
    chk("R1 mask cleared", 32'(o_pend[0]), 4'h1);
    cyc(2);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule